// File: doc/BRIEF.md
# Edge-Latched Bridge Interrupt Controller

This block gathers up to 32 interrupt sources into one interrupt line for a parent controller. Each source is first synchronized to the block clock. A rising edge on a source then sets a sticky bit in the pending register. A separate enable register decides which pending bits may drive the output line. Pending bits are recorded whether or not the source is enabled. Software must therefore clear old events before it enables a source, or the line asserts at once on stale history.

A simple register bus gives access to both registers. Reading either register returns its contents. A write to the enable register replaces it. A write to the pending register acts as a clear mask: every bit written as 0 is cleared and every bit written as 1 is left as it is, so writing all zeros drops every pending event. The number of sources is a parameter. Bit positions at or above that count always read as zero and can never become set.

Top module: `irq_edge_bridge`

## Requirements
- R1: After reset the pending register, the enable register, `rdata_o` and `irq_o` are all 0.
- R2: A 0-to-1 transition on `src_i[k]`, after a `SYNC_STAGES`-flop synchronizer and a one-cycle edge detector, sets pending bit k. A source held high sets its bit only once, so a bit cleared while its source stays high stays clear.
- R3: Pending bits are set by edges regardless of the enable register. A pending but disabled source does not assert `irq_o`.
- R4: A write to the pending register (address 0x00) clears each bit k where `wdata_i[k]` is 0 and leaves each bit where `wdata_i[k]` is 1 unchanged. Writing 0 clears all pending bits.
- R5: When a detected edge and a clearing write hit the same bit in the same cycle, the edge wins and the bit ends up set.
- R6: A write to the enable register (address 0x04) replaces its contents, and a read returns them. Enable bit 1 lets the source reach `irq_o`; enable bit 0 blocks it. The register changes only on such a write.
- R7: `irq_o` is a flop output. It is 1 in the cycle after any bit of (pending AND enable) is 1, and 0 otherwise.
- R8: Bits at positions `NUM_SRC` and above read as 0 in both registers and can never be set.
- R9: Reads from any address other than 0x00 and 0x04 return 0. Writes to such addresses change nothing.
- R10: `rdata_o` is registered. It takes the value of the addressed register at the clock edge where a read request (`req_i`=1, `we_i`=0) is sampled, and it holds that value until the next read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Asynchronous interrupt sources, rising edge active |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address: 0x00 pending, 0x04 enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt line to the parent |

## Verification
The assertions assume that every source pulse or level lasts at least one clock cycle, so the synchronizer can see it. They also assume that a bus access is a single-cycle request with stable address and data, and that `src_i` is free of X after reset. The stimulus drives all inputs on the falling clock edge and holds each one for at least a full cycle. Sources are driven low during reset, so no edge is seen at reset release. Directed phases cover collisions of an edge with a clear in exactly the same cycle, and a random phase mixes pulses, held levels and bus accesses to the mapped addresses and to one unmapped address.

// File: rtl/ieb_pkg.sv
package ieb_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFF_PEND = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_ENA  = 8'h04;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_PEND = 2'd1,
    SEL_ENA  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/ieb_sync.sv
module ieb_sync #(
  parameter int unsigned N      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  output logic [N-1:0] edge_o
);
  logic [STAGES-1:0][N-1:0] stage_q;
  logic [N-1:0]             prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      prev_q  <= '0;
    end else begin
      stage_q[0] <= src_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      prev_q <= stage_q[STAGES-1];
    end
  end

  assign edge_o = stage_q[STAGES-1] & ~prev_q;

  // a detected edge never lasts two cycles on the same bit
  AST_EDGE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_o & $past(edge_o)) == '0); // R2
endmodule

// File: rtl/ieb_pend.sv
module ieb_pend #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] edge_i,
  input  logic [N-1:0] keep_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  // edge has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & keep_i) | edge_i;
  end

  assign pend_o = pend_q;

  AST_SET_NEEDS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & ~$past(pend_q)) & ~$past(edge_i)) == '0); // R2
  AST_EDGE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(edge_i) & ~pend_q) == '0); // R5
  AST_CLEAR_NEEDS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(pend_q) & ~pend_q) & $past(keep_i)) == '0); // R4
endmodule

// File: rtl/ieb_regs.sv
module ieb_regs
  import ieb_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N-1:0]      pend_i,
  output logic [N-1:0]      keep_o,
  output logic [N-1:0]      ena_o,
  output logic [DATA_W-1:0] rdata_o
);
  reg_sel_e          sel;
  logic              wr_ena;
  logic              rd_req;
  logic [N-1:0]      ena_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    unique case (addr_i)
      OFF_PEND: sel = SEL_PEND;
      OFF_ENA:  sel = SEL_ENA;
      default:  sel = SEL_NONE;
    endcase
  end

  assign wr_ena = req_i && we_i && (sel == SEL_ENA);
  assign rd_req = req_i && !we_i;
  assign keep_o = (req_i && we_i && (sel == SEL_PEND)) ? wdata_i[N-1:0] : '1;

  always_comb begin
    unique case (sel)
      SEL_PEND: rd_mux = DATA_W'(pend_i);
      SEL_ENA:  rd_mux = DATA_W'(ena_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ena_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_ena) ena_q <= wdata_i[N-1:0];
      if (rd_req) rdata_q <= rd_mux;
    end
  end

  assign ena_o   = ena_q;
  assign rdata_o = rdata_q;

  AST_ENA_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && addr_i == OFF_ENA) |=> $stable(ena_o)); // R6
  AST_RDATA_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o)); // R10
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i != OFF_PEND && addr_i != OFF_ENA) |=> rdata_o == '0); // R9
endmodule

// File: rtl/irq_edge_bridge.sv
module irq_edge_bridge
  import ieb_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_SRC-1:0]      src_i,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [ieb_pkg::ADDR_W-1:0] addr_i,
  input  logic [ieb_pkg::DATA_W-1:0] wdata_i,
  output logic [ieb_pkg::DATA_W-1:0] rdata_o,
  output logic                    irq_o
);
  logic [NUM_SRC-1:0] edge_vec;
  logic [NUM_SRC-1:0] keep_vec;
  logic [NUM_SRC-1:0] pend_vec;
  logic [NUM_SRC-1:0] ena_vec;
  logic               irq_q;

  initial begin
    AST_PARAM_RANGE: assert (NUM_SRC >= 1 && NUM_SRC <= DATA_W && SYNC_STAGES >= 1); // R8
  end

  ieb_sync #(.N(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .src_i (src_i),
    .edge_o(edge_vec)
  );

  ieb_pend #(.N(NUM_SRC)) u_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .edge_i(edge_vec),
    .keep_i(keep_vec),
    .pend_o(pend_vec)
  );

  ieb_regs #(.N(NUM_SRC)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .pend_i (pend_vec),
    .keep_o (keep_vec),
    .ena_o  (ena_vec),
    .rdata_o(rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(pend_vec & ena_vec);
  end

  assign irq_o = irq_q;

  AST_IRQ_CAUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(pend_vec & ena_vec) != '0); // R7
  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ena_vec) == '0) |-> !irq_o); // R3

  generate
    if (NUM_SRC < DATA_W) begin : g_upper
      AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rdata_o[DATA_W-1:NUM_SRC] == '0); // R8
    end
  endgenerate
endmodule

// File: tb/irq_edge_bridge_bench.sv
module irq_edge_bridge_bench;
  localparam int unsigned NS = 24;
  localparam logic [31:0] VALID = (32'h1 << NS) - 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NS-1:0] src_i = '0;
  logic          req_i = 1'b0;
  logic          we_i = 1'b0;
  logic [7:0]    addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic          irq_o;

  int checks = 0;
  int fails = 0;
  bit model_on = 1'b0;

  always #4 clk_i = ~clk_i;

  irq_edge_bridge #(.NUM_SRC(NS), .SYNC_STAGES(2)) u_irq_edge_bridge (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, updated on each rising edge
  logic [31:0] m_a, m_b, m_old, m_pend, m_ena, m_rd;
  logic        m_irq;
  always @(posedge clk_i or negedge rst_ni) begin
    logic [31:0] nxt_pend, nxt_ena, nxt_rd, rising, keep;
    logic        nxt_irq;
    if (!rst_ni) begin
      m_a = 0; m_b = 0; m_old = 0; m_pend = 0; m_ena = 0; m_rd = 0; m_irq = 0;
    end else begin
      rising = m_b & ~m_old;
      keep = (req_i && we_i && addr_i == 8'h00) ? wdata_i : 32'hFFFF_FFFF;
      nxt_pend = ((m_pend & keep) | rising) & VALID;
      nxt_ena = (req_i && we_i && addr_i == 8'h04) ? (wdata_i & VALID) : m_ena;
      nxt_rd = m_rd;
      if (req_i && !we_i)
        nxt_rd = (addr_i == 8'h00) ? m_pend : (addr_i == 8'h04) ? m_ena : 32'h0;
      nxt_irq = (m_pend & m_ena) != 0;
      m_old = m_b; m_b = m_a; m_a = 32'(src_i);
      m_pend = nxt_pend; m_ena = nxt_ena; m_rd = nxt_rd; m_irq = nxt_irq;
    end
  end

  always @(negedge clk_i) begin
    if (model_on && rst_ni) begin
      check("R7 irq_o vs model", {31'h0, irq_o}, {31'h0, m_irq});
      check("R10 rdata_o vs model", rdata_o, m_rd);
    end
  end

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    req_i = 1; we_i = 0; addr_i = a;
    @(posedge clk_i); @(negedge clk_i);
    req_i = 0;
    check(tag, rdata_o, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(posedge clk_i); @(negedge clk_i);
    req_i = 0; we_i = 0;
  endtask

  task automatic pulse(input logic [NS-1:0] bits);
    src_i = src_i | bits;
    @(negedge clk_i);
    src_i = src_i & ~bits;
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired (all requirements) act=hung exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    model_on = 1;
    @(negedge clk_i);
    check("R1 irq_o after reset", {31'h0, irq_o}, 32'h0);
    check("R1 rdata_o after reset", rdata_o, 32'h0);
    rd(8'h00, 32'h0, "R1 pending after reset");
    rd(8'h04, 32'h0, "R1 enable after reset");

    wr(8'h04, 32'h0000_00F0);
    rd(8'h04, 32'h0000_00F0, "R6 enable readback");

    pulse(24'h000004);
    rd(8'h00, 32'h4, "R3 masked edge latched");
    check("R3 masked pending keeps irq low", {31'h0, irq_o}, 32'h0);

    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, VALID, "R8 enable upper bits read zero");
    @(negedge clk_i);
    check("R7 stale pending asserts irq once enabled", {31'h0, irq_o}, 32'h1);

    wr(8'h00, 32'hFFFF_FFFB);
    rd(8'h00, 32'h0, "R4 zero bit clears");
    @(negedge clk_i);
    check("R7 irq drops after clear", {31'h0, irq_o}, 32'h0);

    pulse(24'h00000B);
    wr(8'h00, 32'hFFFF_FFF5);
    rd(8'h00, 32'h1, "R4 one bits unchanged");

    src_i[8] = 1'b1;
    repeat (4) @(negedge clk_i);
    rd(8'h00, 32'h101, "R2 rising edge sets bit");
    wr(8'h00, 32'hFFFF_FEFF);
    repeat (3) @(negedge clk_i);
    rd(8'h00, 32'h1, "R2 held level does not re-set");
    src_i[8] = 1'b0;
    repeat (4) @(negedge clk_i);
    rd(8'h00, 32'h1, "R2 falling edge ignored");

    wr(8'h00, 32'h0);
    rd(8'h00, 32'h0, "R4 all-zero write clears all");

    pulse(24'h000040);
    src_i[5] = 1'b1;
    @(posedge clk_i); @(posedge clk_i); @(negedge clk_i);
    wr(8'h00, 32'h0);
    src_i[5] = 1'b0;
    rd(8'h00, 32'h20, "R5 edge wins over same-cycle clear");

    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, 32'h20, "R8 all-ones write sets nothing");
    wr(8'h08, 32'h0);
    rd(8'h04, VALID, "R9 unmapped write ignored");
    rd(8'h08, 32'h0, "R9 unmapped read zero");

    rd(8'h04, VALID, "R10 read value");
    wr(8'h04, 32'h3);
    repeat (2) @(negedge clk_i);
    check("R10 rdata held without read", rdata_o, VALID);
    rd(8'h04, 32'h3, "R6 enable rewrite");

    for (int i = 0; i < 600; i++) begin
      int op;
      src_i = NS'($urandom) & NS'($urandom);
      op = $urandom_range(0, 5);
      if (op < 3) begin
        req_i = 1;
        we_i = op[0];
        addr_i = 8'(4 * $urandom_range(0, 2));
        wdata_i = (addr_i == 8'h00) ? ~($urandom & $urandom & $urandom) : $urandom;
      end
      @(negedge clk_i);
      req_i = 0; we_i = 0;
    end

    repeat (4) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule